// File: doc/BRIEF.md
# Microsecond Busy-Wait Delay Unit

The unit waits for a given number of microseconds by watching a free-running 16-bit timer that counts down. A request brings a signed microsecond count. The unit takes a sample of the timer counter in the cycle it accepts the request, so the time it spends setting up is part of the wait. It then turns the microsecond count into a budget of timer ticks. After that it samples the counter once per cycle and subtracts the ticks that passed since the last sample. When the budget is used up, it reports completion.

Two paths do the conversion. A request shorter than the short-delay limit uses a fixed-point multiply by a reciprocal constant, which rounds up. A longer request uses a rounded-up division of the product of the count and the programmed timer frequency by one million. A sequential divider computes it, one quotient bit per cycle. Each per-cycle delta is corrected for counter reload against the programmed maximum count. The frequency and maximum-count values come from registers outside the block and stay constant while a request runs.

Top module: `dly_wait_unit`

## Requirements
- R1: After reset, busy_o and done_o are both low.
- R2: When busy_o is low and start_i is high at a clock edge, the request is accepted. The counter value at that edge is the first sample, and busy_o is high after that edge.
- R3: A request of zero or a negative count gives a zero budget. done_o goes high one cycle after acceptance.
- R4: A request from 1 to 255 gets a budget of (n*39099 + 32767) >> 15. Counting of ticks begins with the counter value at the second edge after acceptance.
- R5: A request of 256 or more gets a budget of (n*freq + 999999) / 1000000, computed with a 64-bit dividend. Counting begins 66 edges after acceptance. If this budget is zero, done_o goes high at that point instead.
- R6: At each counting edge, delta = previous sample minus current sample, and the current sample becomes the previous sample.
- R7: A negative delta has the maximum count added to it. If it is still negative, it is taken as zero.
- R8: The request ends at the counting edge where the remaining budget falls to zero or below. done_o then stays high for exactly one cycle with busy_o high, and both are low in the cycle after.
- R9: start_i is ignored while busy_o is high, including the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe |
| usec_i | input | 32 | Signed microsecond count |
| tick_cnt_i | input | 16 | Current value of the down-counting timer |
| freq_i | input | 32 | Timer input frequency in Hz |
| max_cnt_i | input | 16 | Reload value of the timer |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: 32-bit counts and frequency, a 16-bit counter and a 64-bit dividend. This means the long path runs the full 64-step division. It also means a frequency near 2.4 MHz and requests of tens of thousands of microseconds can be reached in a few hundred cycles. The bench does this by moving the counter by nearly a full reload per cycle. Lowering the maximum count to 100 while the counter jumps at random puts both the wrap correction and the clamp to zero in reach. A frequency of zero or 1000 puts the zero-budget and one-tick results of the long path in reach.

// File: rtl/dly_pkg.sv
package dly_pkg;
    // Sequencer phases of the delay unit.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_DIV,
        ST_WAIT,
        ST_DONE
    } dly_state_t;
endpackage

// File: rtl/dly_conv.sv
// Microsecond-to-tick conversion front end.
// Produces the short-path budget with a fixed-point reciprocal multiply,
// and the rounded-up dividend for the long path. Assumes the caller
// uses short_bud_o only when short_o is set and zero_o is clear.
module dly_conv #(
    parameter int US_W      = 32,
    parameter int FREQ_W    = 32,
    parameter int PROD_W    = 64,
    parameter int SHORT_LIM = 256,
    parameter int FIX_MULT  = 39099,
    parameter int FIX_SHIFT = 15,
    parameter int SCALE     = 1000000
) (
    input  logic signed [US_W-1:0]   usec_i,
    input  logic        [FREQ_W-1:0] freq_i,
    output logic                     zero_o,
    output logic                     short_o,
    output logic        [PROD_W-1:0] short_bud_o,
    output logic        [PROD_W-1:0] long_num_o
);
    localparam logic [PROD_W-1:0] RND_FIX  = PROD_W'((1 << FIX_SHIFT) - 1);
    localparam logic [PROD_W-1:0] RND_LONG = PROD_W'(SCALE - 1);

    logic [PROD_W-1:0] mag;

    // Classify the request and form both conversion results.
    always_comb begin
        mag         = PROD_W'($unsigned(usec_i));
        zero_o      = usec_i[US_W-1] || (usec_i == '0);
        short_o     = mag < PROD_W'(SHORT_LIM);
        short_bud_o = (mag * PROD_W'(FIX_MULT) + RND_FIX) >> FIX_SHIFT;
        long_num_o  = mag * PROD_W'(freq_i) + RND_LONG;
    end
endmodule

// File: rtl/dly_div.sv
// Restoring divider by a fixed constant, one quotient bit per cycle.
// load_i starts a division of num_i. fin_o pulses once NUM_W steps
// later, and quo_o holds the quotient from then on.
module dly_div #(
    parameter int NUM_W = 64,
    parameter int DEN   = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    output logic             run_o,
    output logic             fin_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int DEN_W = $clog2(DEN + 1);
    localparam int STP_W = $clog2(NUM_W + 1);
    localparam logic [DEN_W:0] DEN_V = (DEN_W+1)'(DEN);

    logic [DEN_W-1:0] rem_q, rem_n;
    logic [DEN_W:0]   trial, diff;
    logic [STP_W-1:0] step_q;
    logic             ge;

    // One shift-subtract step of the restoring algorithm.
    always_comb begin
        trial = {rem_q, quo_o[NUM_W-1]};
        diff  = trial - DEN_V;
        ge    = trial >= DEN_V;
        rem_n = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
    end

    // Step sequencing, quotient shift register and finish pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_o  <= '0;
            step_q <= '0;
            run_o  <= 1'b0;
            fin_o  <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (load_i) begin
                quo_o  <= num_i;
                rem_q  <= '0;
                step_q <= STP_W'(NUM_W);
                run_o  <= 1'b1;
            end else if (run_o) begin
                rem_q  <= rem_n;
                quo_o  <= {quo_o[NUM_W-2:0], ge};
                step_q <= step_q - 1'b1;
                if (step_q == STP_W'(1)) begin
                    run_o <= 1'b0;
                    fin_o <= 1'b1;
                end
            end
        end
    end

    a_r5_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> !run_o);
    a_r5_load_runs: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> run_o);
endmodule

// File: rtl/dly_delta.sv
// Elapsed ticks between two samples of a down counter, corrected for reload.
// A negative raw difference gets the reload value added to it. A result
// that is still negative is clamped to zero.
module dly_delta #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] prev_i,
    input  logic [CNT_W-1:0] cur_i,
    input  logic [CNT_W-1:0] max_i,
    output logic [CNT_W-1:0] delta_o
);
    logic signed [CNT_W+1:0] raw, adj;

    // Difference, wrap fix-up and clamp.
    always_comb begin
        raw = $signed({2'b00, prev_i}) - $signed({2'b00, cur_i});
        adj = raw + $signed({2'b00, max_i});
        if (!raw[CNT_W+1])
            delta_o = raw[CNT_W-1:0];
        else if (adj[CNT_W+1])
            delta_o = '0;
        else
            delta_o = adj[CNT_W-1:0];
    end
endmodule

// File: rtl/dly_wait_unit.sv
// Microsecond busy-wait delay unit (top).
// Accepts a signed microsecond request and samples the timer counter at
// once. It converts the request to a tick budget on the short or long path,
// then spends the budget on wrap-corrected counter deltas, one per cycle.
// Assumes freq_i and max_cnt_i stay stable while busy_o is high.
module dly_wait_unit
    import dly_pkg::*;
#(
    parameter int US_W      = 32,
    parameter int CNT_W     = 16,
    parameter int FREQ_W    = 32,
    parameter int SHORT_LIM = 256,
    parameter int FIX_MULT  = 39099,
    parameter int FIX_SHIFT = 15,
    parameter int SCALE     = 1000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic signed [US_W-1:0]  usec_i,
    input  logic        [CNT_W-1:0] tick_cnt_i,
    input  logic       [FREQ_W-1:0] freq_i,
    input  logic        [CNT_W-1:0] max_cnt_i,
    output logic                    busy_o,
    output logic                    done_o
);
    localparam int PROD_W = US_W + FREQ_W;
    localparam int REM_W  = PROD_W + 1;

    dly_state_t               state_q;
    logic signed [US_W-1:0]   n_q;
    logic        [CNT_W-1:0]  prev_q;
    logic signed [REM_W-1:0]  left_q, left_nxt;
    logic                     is_zero, is_short, div_load, div_run, div_fin;
    logic        [PROD_W-1:0] short_bud, long_num, quo;
    logic        [CNT_W-1:0]  delta;
    logic                     spent;

    dly_conv #(
        .US_W(US_W), .FREQ_W(FREQ_W), .PROD_W(PROD_W),
        .SHORT_LIM(SHORT_LIM), .FIX_MULT(FIX_MULT),
        .FIX_SHIFT(FIX_SHIFT), .SCALE(SCALE)
    ) u_conv (
        .usec_i(n_q), .freq_i(freq_i), .zero_o(is_zero),
        .short_o(is_short), .short_bud_o(short_bud), .long_num_o(long_num)
    );

    dly_div #(.NUM_W(PROD_W), .DEN(SCALE)) u_div (
        .clk(clk), .rst_n(rst_n), .load_i(div_load), .num_i(long_num),
        .run_o(div_run), .fin_o(div_fin), .quo_o(quo)
    );

    dly_delta #(.CNT_W(CNT_W)) u_delta (
        .prev_i(prev_q), .cur_i(tick_cnt_i), .max_i(max_cnt_i), .delta_o(delta)
    );

    // Budget after this cycle's delta, and whether it is used up.
    always_comb begin
        left_nxt = left_q - $signed({{(REM_W-CNT_W){1'b0}}, delta});
        spent    = left_nxt[REM_W-1] || (left_nxt == '0);
        div_load = (state_q == ST_CONV) && !is_zero && !is_short;
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
    end

    // Request sequencer: accept, convert, divide, count, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            n_q     <= '0;
            prev_q  <= '0;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    prev_q  <= tick_cnt_i;
                    n_q     <= usec_i;
                    state_q <= ST_CONV;
                end
                ST_CONV: begin
                    if (is_zero) begin
                        left_q  <= '0;
                        state_q <= ST_DONE;
                    end else if (is_short) begin
                        left_q  <= $signed({1'b0, short_bud});
                        state_q <= (short_bud == '0) ? ST_DONE : ST_WAIT;
                    end else begin
                        state_q <= ST_DIV;
                    end
                end
                ST_DIV: if (div_fin) begin
                    left_q  <= $signed({1'b0, quo});
                    state_q <= (quo == '0) ? ST_DONE : ST_WAIT;
                end
                ST_WAIT: begin
                    prev_q <= tick_cnt_i;
                    left_q <= left_nxt;
                    if (spent)
                        state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_CONV));
    a_r3_zero_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && is_zero) |=> done_o);
    a_r6_prev_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |=> (prev_q == $past(tick_cnt_i)));
    a_r7_delta_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (delta <= prev_q || delta < max_cnt_i));
endmodule

// File: tb/dly_wait_unit_test.sv
`timescale 1ns/1ps
module dly_wait_unit_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic signed [31:0] usec_i = '0;
    logic        [15:0] tick_cnt_i = 16'hFFFF;
    logic        [31:0] freq_i = 32'd2457600;
    logic        [15:0] max_cnt_i = 16'd60000;
    logic               busy_o, done_o;

    int tests = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    int tick_mode = 0, tick_step = 1;

    // Reference model state
    bit     m_busy = 0, m_done = 0;
    longint m_left = 0;
    int     m_prev = 0, m_lat = 0;

    dly_wait_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .usec_i(usec_i),
        .tick_cnt_i(tick_cnt_i), .freq_i(freq_i), .max_cnt_i(max_cnt_i),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    // Behavioural model advanced on every clock edge.
    always @(posedge clk) begin
        longint n, d;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0; m_prev = 0; m_lat = 0;
        end else if (m_done) begin
            m_done = 0; m_busy = 0;
        end else if (m_busy) begin
            if (m_lat > 0) begin
                m_lat--;
                if (m_lat == 0 && m_left <= 0) m_done = 1;
            end else begin
                d = longint'(m_prev) - longint'(tick_cnt_i);
                if (d < 0) d += longint'(max_cnt_i);
                if (d < 0) d = 0;
                m_left -= d;
                m_prev = tick_cnt_i;
                if (m_left <= 0) m_done = 1;
            end
        end else if (start_i) begin
            m_busy = 1;
            m_prev = tick_cnt_i;
            n = longint'(usec_i);
            if (n <= 0) begin
                m_left = 0; m_lat = 1;
            end else if (n < 256) begin
                m_left = (n * 39099 + 32767) / 32768; m_lat = 1;
            end else begin
                m_left = (n * longint'(freq_i) + 999999) / 1000000; m_lat = 66;
            end
        end
    end

    // Compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            tests++;
            if (busy_o !== m_busy || done_o !== m_done) begin
                fails++;
                $display("FAIL %s: busy=%0b done=%0b expected busy=%0b done=%0b",
                         cur_req, busy_o, done_o, m_busy, m_done);
            end
        end
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic cyc();
        @(negedge clk);
        case (tick_mode)
            1: tick_cnt_i = (tick_cnt_i >= 16'(tick_step)) ? tick_cnt_i - 16'(tick_step)
                          : 16'(int'(tick_cnt_i) + int'(max_cnt_i) - tick_step);
            2: tick_cnt_i = 16'($urandom_range(0, 65535));
            default: ;
        endcase
    endtask

    task automatic req(input int n, input bit hold);
        int dn = 0;
        int guard = 0;
        start_i = 1'b1; usec_i = n;
        cyc();
        if (!hold) start_i = 1'b0;
        usec_i = -n;
        while (guard < 20000) begin
            cyc();
            guard++;
            if (done_o) begin dn++; start_i = 1'b0; end
            if (!busy_o && !m_busy) break;
        end
        start_i = 1'b0;
        tests++;
        if (dn != 1) begin
            fails++;
            $display("FAIL %s R8 n=%0d: done pulses=%0d expected=1", cur_req, n, dn);
        end
    endtask

    initial begin
        repeat (3) cyc();
        tests++;
        if (busy_o !== 1'b0 || done_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: busy=%0b done=%0b expected 0 0", busy_o, done_o);
        end
        rst_n = 1'b1;
        cyc();
        cur_req = "R3"; req(0, 0); req(-7, 0);
        cur_req = "R4"; tick_mode = 1; tick_step = 3;
        req(1, 0); req(17, 0); req(255, 0);
        cur_req = "R5"; tick_step = 59000;
        req(256, 0); req(20000, 0);
        freq_i = 32'd0; req(300, 0);
        freq_i = 32'd1000; req(1000, 0);
        freq_i = 32'd2457600;
        cur_req = "R2 R6"; tick_mode = 2; req(50, 0); req(400, 0);
        cur_req = "R7"; max_cnt_i = 16'd100; req(120, 0);
        max_cnt_i = 16'hFFFF; tick_mode = 1; tick_step = 40000; req(5000, 0);
        cur_req = "R9"; max_cnt_i = 16'd60000; tick_step = 5; req(100, 1);
        repeat (3) cyc();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule